// File: doc/BRIEF.md
# Address and Data Breakpoint Comparator Unit

This debug-support block watches three streams every clock cycle: the instruction fetch address, the operand access address and the data value of that access. It compares them against 32 programmable point registers. The points are organised as 8 groups. Each group holds two pairs of two points and owns 4 consecutive channels. A pair works either as two independent single points or, with its range bit set, as one inclusive address window. Each pair is steered by its own source field to one of the three streams. A group can also be chained, so that its first pair watches the operand address and its second pair watches the data value. The group then only reports when both match in the same access.

Each match sets a sticky per-channel bit in a 32-bit detect register, and a break request is raised while any bit is set. The first detection after the register is empty also latches the fetch and operand addresses of that cycle into two capture registers. Software programs points, masks and pair settings through a simple word-addressed register bus with combinational read data. It clears detect bits by writing ones to them.

Top module: `bkpt_unit`

## Requirements
- R1: After reset the detect register (0x10), both capture registers (0x08, 0x0C) and `brk_req` are zero. Every pair configuration reads 0x3, which means disabled.
- R2: Pair p's configuration sits at 0x300+4p, with bits [1:0] selecting the source: 0 fetch address, 1 operand address, 2 data value, 3 off. In single mode, point c (register 0x100+4c, belonging to pair c/2) sets detect bit c at the clock edge that samples an equal, qualified source value. Bit c is readable in the next cycle.
- R3: Fetch-address comparisons count only when `fetch_valid` is high. Operand-address and data comparisons count only when `acc_valid` is high.
- R4: When configuration bit 2 (range) is set, pair p matches when lo ≤ value ≤ hi, using unsigned compare and inclusive bounds. Here lo is point 2p and hi is point 2p+1. A range match sets both detect bits 2p and 2p+1.
- R5: When configuration bit 3 (mask enable) is set, the mask register of pair p at 0x200+4p marks with ones the bit positions that are ignored. The mask applies to both points and to range bounds.
- R6: When configuration bit 4 of pair 2g is set, group g is chained. Pair 2g compares the operand address and pair 2g+1 compares the data value, whatever their source fields say. A pair's bits are set only if the other pair of the group also matches in the same cycle with `acc_valid` high.
- R7: Detect bits are sticky. Writing 1 to a bit of 0x10 clears it, and writing 0 leaves it unchanged. A match in the same cycle as the clear wins.
- R8: `brk_req` is high exactly while the detect register is non-zero.
- R9: The capture registers latch `fetch_addr` (0x08) and `oper_addr` (0x0C) of the cycle in which a detection occurs while the detect register is all zero. They hold their value while any detect bit is set.
- R10: Point, mask and configuration registers read back what was written. Configuration reads return only bits [4:0], and the upper bits read zero.
- R11: Writes to the capture registers at 0x08 and 0x0C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Qualifies `fetch_addr` this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| acc_valid | input | 1 | Qualifies `oper_addr` and `data_val` this cycle |
| oper_addr | input | 32 | Operand access address |
| data_val | input | 32 | Data value of the operand access |
| bus_addr | input | 12 | Register byte address (word aligned) |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| brk_req | output | 1 | Break request, high while any detect bit is set |

## Verification
The bench aims at the inclusive edges of a range window, one value inside each bound and one just outside. A design with an off-by-one compare or swapped bounds would then miss a hit or report a false one. Chained groups are driven with only one of the two conditions true, which shows a design that lets either half fire on its own. Streams are driven without their strobe, which exposes a comparator that ignores qualification. Random traffic with interleaved write-one-to-clear checks that the capture registers are frozen after the first detection, and that a clear and a fresh hit in the same cycle leave the bit set.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int W     = 32;
    localparam int CFG_W = 5;

    typedef logic [W-1:0] word_t;

    typedef enum logic [1:0] {
        SRC_FETCH = 2'd0,
        SRC_OPER  = 2'd1,
        SRC_DATA  = 2'd2,
        SRC_OFF   = 2'd3
    } src_e;

    // bits [4:0] = {chain, mask_en, range_en, src[1:0]}
    typedef struct packed {
        logic chain;
        logic mask_en;
        logic range_en;
        src_e src;
    } pair_cfg_t;

    localparam pair_cfg_t CFG_RESET = '{chain: 1'b0, mask_en: 1'b0, range_en: 1'b0, src: SRC_OFF};

    localparam logic [11:0] OFF_CAP_IA = 12'h008;
    localparam logic [11:0] OFF_CAP_OA = 12'h00C;
    localparam logic [11:0] OFF_STAT   = 12'h010;
    localparam logic [3:0]  PG_POINT   = 4'h1;
    localparam logic [3:0]  PG_MASK    = 4'h2;
    localparam logic [3:0]  PG_CFG     = 4'h3;

    function automatic word_t care_bits(input logic en, input word_t m);
        return en ? ~m : '1;
    endfunction

endpackage

// File: rtl/bkpt_pair.sv
module bkpt_pair
    import bkpt_pkg::*;
(
    input  logic  vld,
    input  word_t val,
    input  word_t lo,
    input  word_t hi,
    input  word_t msk,
    input  logic  range_en,
    input  logic  mask_en,
    output logic [1:0] hit
);
    word_t care, v, l, h;
    logic  in_win;

    always_comb begin
        care   = care_bits(mask_en, msk);
        v      = val & care;
        l      = lo & care;
        h      = hi & care;
        in_win = (v >= l) && (v <= h);
        if (range_en)
            hit = {2{vld && in_win}};
        else
            hit = {vld && (v == h), vld && (v == l)};
    end
endmodule

// File: rtl/bkpt_group.sv
module bkpt_group
    import bkpt_pkg::*;
(
    input  logic                 fetch_valid,
    input  word_t                fetch_addr,
    input  logic                 acc_valid,
    input  word_t                oper_addr,
    input  word_t                data_val,
    input  logic [3:0][W-1:0]    pts,
    input  logic [1:0][W-1:0]    msks,
    input  pair_cfg_t [1:0]      cfgs,
    output logic [3:0]           hit
);
    logic [1:0][1:0] ph;
    logic            chained;

    assign chained = cfgs[0].chain;

    for (genvar k = 0; k < 2; k++) begin : g_pair
        src_e  src;
        word_t sval;
        logic  svld;

        always_comb begin
            if (chained) src = (k == 0) ? SRC_OPER : SRC_DATA;
            else         src = cfgs[k].src;
            unique case (src)
                SRC_FETCH: begin sval = fetch_addr; svld = fetch_valid; end
                SRC_OPER:  begin sval = oper_addr;  svld = acc_valid;   end
                SRC_DATA:  begin sval = data_val;   svld = acc_valid;   end
                default:   begin sval = '0;         svld = 1'b0;        end
            endcase
        end

        bkpt_pair u_pair (
            .vld      (svld),
            .val      (sval),
            .lo       (pts[2*k]),
            .hi       (pts[2*k+1]),
            .msk      (msks[k]),
            .range_en (cfgs[k].range_en),
            .mask_en  (cfgs[k].mask_en),
            .hit      (ph[k])
        );
    end

    always_comb begin
        if (chained)
            hit = {ph[1] & {2{|ph[0]}}, ph[0] & {2{|ph[1]}}};
        else
            hit = {ph[1], ph[0]};
    end

    always_comb begin
        if (!fetch_valid && !acc_valid)
            a_r3_no_hit_unqualified: assert (hit == 4'b0);
        if (chained && !acc_valid)
            a_r6_chain_needs_access: assert (hit == 4'b0);
    end
endmodule

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
    import bkpt_pkg::*;
#(
    parameter int NGRP = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [11:0]               bus_addr,
    input  logic                      bus_wr,
    input  word_t                     bus_wdata,
    output logic [4*NGRP-1:0][W-1:0]  pts,
    output logic [2*NGRP-1:0][W-1:0]  msks,
    output pair_cfg_t [2*NGRP-1:0]    cfgs,
    output word_t                     rdata
);
    localparam int NCH   = 4 * NGRP;
    localparam int NPAIR = 2 * NGRP;

    logic [3:0] page;
    logic [5:0] idx;

    assign page = bus_addr[11:8];
    assign idx  = bus_addr[7:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            pts  <= '0;
            msks <= '0;
            for (int i = 0; i < NPAIR; i++) cfgs[i] <= CFG_RESET;
        end else if (bus_wr) begin
            for (int i = 0; i < NCH; i++)
                if (page == PG_POINT && idx == 6'(i)) pts[i] <= bus_wdata;
            for (int i = 0; i < NPAIR; i++) begin
                if (page == PG_MASK && idx == 6'(i)) msks[i] <= bus_wdata;
                if (page == PG_CFG  && idx == 6'(i)) cfgs[i] <= pair_cfg_t'(bus_wdata[CFG_W-1:0]);
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (page == PG_POINT && idx == 6'(i)) rdata = pts[i];
        for (int i = 0; i < NPAIR; i++) begin
            if (page == PG_MASK && idx == 6'(i)) rdata = msks[i];
            if (page == PG_CFG  && idx == 6'(i)) rdata[CFG_W-1:0] = cfgs[i];
        end
    end
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int NGRP = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_addr,
    input  logic        acc_valid,
    input  logic [31:0] oper_addr,
    input  logic [31:0] data_val,
    input  logic [11:0] bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        brk_req
);
    localparam int NCH   = 4 * NGRP;
    localparam int NPAIR = 2 * NGRP;

    logic [NCH-1:0][W-1:0]   pts;
    logic [NPAIR-1:0][W-1:0] msks;
    pair_cfg_t [NPAIR-1:0]   cfgs;
    word_t                   cfg_rdata;
    logic [NCH-1:0]          hit, det, w1c;
    word_t                   cap_ia, cap_oa;

    bkpt_regfile #(.NGRP(NGRP)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pts       (pts),
        .msks      (msks),
        .cfgs      (cfgs),
        .rdata     (cfg_rdata)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        bkpt_group u_grp (
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .acc_valid   (acc_valid),
            .oper_addr   (oper_addr),
            .data_val    (data_val),
            .pts         (pts[4*g+3 -: 4]),
            .msks        (msks[2*g+1 -: 2]),
            .cfgs        (cfgs[2*g+1 -: 2]),
            .hit         (hit[4*g+3 -: 4])
        );
    end

    assign w1c = (bus_wr && bus_addr == OFF_STAT) ? bus_wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            det    <= '0;
            cap_ia <= '0;
            cap_oa <= '0;
        end else begin
            det <= (det & ~w1c) | hit;
            if (det == '0 && hit != '0) begin
                cap_ia <= fetch_addr;
                cap_oa <= oper_addr;
            end
        end
    end

    assign brk_req = |det;

    always_comb begin
        if (bus_addr == OFF_CAP_IA)      bus_rdata = cap_ia;
        else if (bus_addr == OFF_CAP_OA) bus_rdata = cap_oa;
        else if (bus_addr == OFF_STAT)   bus_rdata = 32'(det);
        else                             bus_rdata = cfg_rdata;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (det == '0 && cap_ia == '0 && cap_oa == '0));

    a_r7_sticky_bits: assert property (@(posedge clk) disable iff (rst)
        ((det & $past(det & ~w1c)) == $past(det & ~w1c)));

    a_r9_capture_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(det) != '0) |-> (cap_ia == $past(cap_ia) && cap_oa == $past(cap_oa)));
endmodule

// File: tb/sim_bkpt_unit.sv
module sim_bkpt_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] oper_addr = '0;
    logic [31:0] data_val = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        brk_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_pt [32];
    logic [31:0] m_mk [16];
    logic [4:0]  m_cf [16];

    always #4 clk = ~clk;

    bkpt_unit u0 (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .acc_valid(acc_valid), .oper_addr(oper_addr), .data_val(data_val),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .brk_req(brk_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (a[11:8] == 4'h1) m_pt[a[7:2]] = d;
        if (a[11:8] == 4'h2) m_mk[a[5:2]] = d;
        if (a[11:8] == 4'h3) m_cf[a[5:2]] = d[4:0];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic step(input logic fv, input logic [31:0] fa, input logic av,
                        input logic [31:0] oa, input logic [31:0] dv);
        @(negedge clk);
        fetch_valid = fv; fetch_addr = fa; acc_valid = av; oper_addr = oa; data_val = dv;
        @(negedge clk);
        fetch_valid = 1'b0; acc_valid = 1'b0;
    endtask

    function automatic logic [1:0] pair_hit(input int p, input logic [1:0] src,
        input logic fv, input logic [31:0] fa, input logic av, input logic [31:0] oa, input logic [31:0] dv);
        logic [31:0] v, c;
        logic ok;
        case (src)
            2'd0: begin v = fa; ok = fv; end
            2'd1: begin v = oa; ok = av; end
            2'd2: begin v = dv; ok = av; end
            default: begin v = 0; ok = 1'b0; end
        endcase
        c = m_cf[p][3] ? ~m_mk[p] : 32'hFFFF_FFFF;
        if (!ok) return 2'b00;
        if (m_cf[p][2]) begin
            if (((v & c) >= (m_pt[2*p] & c)) && ((v & c) <= (m_pt[2*p+1] & c))) return 2'b11;
            return 2'b00;
        end
        return {(v & c) == (m_pt[2*p+1] & c), (v & c) == (m_pt[2*p] & c)};
    endfunction

    function automatic logic [31:0] model_hits(input logic fv, input logic [31:0] fa,
        input logic av, input logic [31:0] oa, input logic [31:0] dv);
        logic [31:0] r = '0;
        for (int g = 0; g < 8; g++) begin
            logic [1:0] a, b;
            if (m_cf[2*g][4]) begin
                a = pair_hit(2*g, 2'd1, fv, fa, av, oa, dv);
                b = pair_hit(2*g+1, 2'd2, fv, fa, av, oa, dv);
                if (a == 0 || b == 0) begin a = 0; b = 0; end
            end else begin
                a = pair_hit(2*g, m_cf[2*g][1:0], fv, fa, av, oa, dv);
                b = pair_hit(2*g+1, m_cf[2*g+1][1:0], fv, fa, av, oa, dv);
            end
            r[4*g +: 4] = {b, a};
        end
        return r;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] mdet, mia, moa, h;
        void'($urandom(32'd7719));
        for (int i = 0; i < 32; i++) m_pt[i] = 0;
        for (int i = 0; i < 16; i++) begin m_mk[i] = 0; m_cf[i] = 5'h3; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(12'h010, d); chk("R1 status", d, 0);
        rd(12'h008, d); chk("R1 cap_ia", d, 0);
        rd(12'h00C, d); chk("R1 cap_oa", d, 0);
        rd(12'h304, d); chk("R1 cfg off", d, 32'h3);
        chk("R1 brk_req", 32'(brk_req), 0);

        // R10 readback
        wr(12'h114, 32'hDEAD_BEEF); rd(12'h114, d); chk("R10 point", d, 32'hDEAD_BEEF);
        wr(12'h23C, 32'h0F0F_0001); rd(12'h23C, d); chk("R10 mask", d, 32'h0F0F_0001);
        wr(12'h33C, 32'hFFFF_FFFF); rd(12'h33C, d); chk("R10 cfg width", d, 32'h1F);
        wr(12'h33C, 32'h3);

        // R2 single point on fetch address
        wr(12'h100, 32'h0000_1000); wr(12'h104, 32'hFFFF_0000); wr(12'h300, 32'h0);
        step(1'b0, 32'h1000, 1'b0, 0, 0);
        rd(12'h010, d); chk("R3 fetch not qualified", d, 0);
        step(1'b1, 32'h1000, 1'b0, 32'h55, 0);
        rd(12'h010, d); chk("R2 single point", d, 32'h1);
        chk("R8 brk_req set", 32'(brk_req), 1);
        rd(12'h008, d); chk("R9 cap_ia", d, 32'h1000);
        rd(12'h00C, d); chk("R9 cap_oa", d, 32'h55);
        step(1'b0, 0, 1'b0, 0, 0);
        rd(12'h010, d); chk("R7 sticky", d, 32'h1);

        // R4 range on operand address (pair 1, points 2,3)
        wr(12'h108, 32'h200); wr(12'h10C, 32'h2FF); wr(12'h304, 32'h5);
        step(1'b0, 0, 1'b0, 32'h250, 0);
        rd(12'h010, d); chk("R3 access not qualified", d, 32'h1);
        step(1'b1, 32'h7777, 1'b1, 32'h250, 0);
        rd(12'h010, d); chk("R4 range mid", d, 32'hD);
        rd(12'h008, d); chk("R9 cap_ia held", d, 32'h1000);
        rd(12'h00C, d); chk("R9 cap_oa held", d, 32'h55);
        wr(12'h008, 32'h1234_5678);
        rd(12'h008, d); chk("R11 cap_ia read-only", d, 32'h1000);
        wr(12'h00C, 32'h1234_5678);
        rd(12'h00C, d); chk("R11 cap_oa read-only", d, 32'h55);
        wr(12'h010, 32'h1);
        rd(12'h010, d); chk("R7 w1c partial", d, 32'hC);
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h010, d); chk("R7 w1c all", d, 0);
        chk("R8 brk_req clear", 32'(brk_req), 0);
        step(1'b0, 0, 1'b1, 32'h200, 0);
        rd(12'h010, d); chk("R4 range lower bound", d, 32'hC);
        rd(12'h00C, d); chk("R9 recapture", d, 32'h200);
        wr(12'h010, 32'hC);
        step(1'b0, 0, 1'b1, 32'h2FF, 0);
        rd(12'h010, d); chk("R4 range upper bound", d, 32'hC);
        wr(12'h010, 32'hC);
        step(1'b0, 0, 1'b1, 32'h300, 0);
        rd(12'h010, d); chk("R4 above range", d, 0);
        step(1'b0, 0, 1'b1, 32'h1FF, 0);
        rd(12'h010, d); chk("R4 below range", d, 0);

        // R5 mask on data (pair 2, points 4,5)
        wr(12'h110, 32'hAB0); wr(12'h114, 32'hFFFF_0000); wr(12'h208, 32'hF); wr(12'h308, 32'hA);
        step(1'b0, 0, 1'b1, 0, 32'hABC);
        rd(12'h010, d); chk("R5 masked match", d, 32'h10);
        wr(12'h010, 32'hFFFF_FFFF);
        step(1'b0, 0, 1'b1, 0, 32'hAC0);
        rd(12'h010, d); chk("R5 unmasked bit differs", d, 0);

        // R6 chained group 2 (pairs 4,5, points 8..11)
        wr(12'h120, 32'h4000); wr(12'h124, 32'h4004); wr(12'h128, 32'h77); wr(12'h12C, 32'h88);
        wr(12'h314, 32'h3); wr(12'h310, 32'h10);
        step(1'b0, 0, 1'b1, 32'h4000, 32'h77);
        rd(12'h010, d); chk("R6 chain both", d, 32'h500);
        wr(12'h010, 32'hFFFF_FFFF);
        step(1'b0, 0, 1'b1, 32'h4000, 32'h99);
        rd(12'h010, d); chk("R6 chain addr only", d, 0);
        step(1'b0, 0, 1'b1, 32'h1234, 32'h77);
        rd(12'h010, d); chk("R6 chain data only", d, 0);

        // R7 clear and hit in same cycle: hit wins
        @(negedge clk);
        acc_valid = 1'b1; oper_addr = 32'h4004; data_val = 32'h88;
        bus_addr = 12'h010; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; bus_wr = 1'b0;
        rd(12'h010, d); chk("R7 hit beats clear", d, 32'hA00);
        wr(12'h010, 32'hFFFF_FFFF);

        // Random phase: R2..R9 against the bench model
        for (int i = 0; i < 32; i++) wr(12'(12'h100 + 4*i), $urandom % 16);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] mv;
            case ($urandom % 4) 0: mv = 0; 1: mv = 1; 2: mv = 3; default: mv = 8; endcase
            wr(12'(12'h200 + 4*i), mv);
            wr(12'(12'h300 + 4*i), (($urandom % 4) == 0 ? 32'h10 : 32'h0) | ($urandom % 16));
        end
        rd(12'h008, mia); rd(12'h00C, moa);
        mdet = 0;
        for (int n = 0; n < 3000; n++) begin
            logic fv, av;
            logic [31:0] fa, oa, dv, w;
            rd(12'h010, d); chk("R2 random status", d, mdet);
            chk("R8 random brk_req", 32'(brk_req), 32'(mdet != 0));
            rd(12'h008, d); chk("R9 random cap_ia", d, mia);
            rd(12'h00C, d); chk("R9 random cap_oa", d, moa);
            fv = $urandom % 2; av = $urandom % 2;
            fa = $urandom % 16; oa = $urandom % 16; dv = $urandom % 16;
            w = (($urandom % 4) == 0) ? $urandom : 32'h0;
            fetch_valid = fv; fetch_addr = fa; acc_valid = av; oper_addr = oa; data_val = dv;
            bus_addr = 12'h010; bus_wdata = w; bus_wr = (w != 0);
            h = model_hits(fv, fa, av, oa, dv);
            if (mdet == 0 && h != 0) begin mia = fa; moa = oa; end
            mdet = (mdet & ~(bus_wr ? w : 32'h0)) | h;
            @(negedge clk);
        end
        bus_wr = 1'b0; fetch_valid = 1'b0; acc_valid = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule